// File: doc/BRIEF.md
# CPU Status Flag Register Unit

This block stores the condition and mode flags of an 8-bit accumulator-style processor. The flags are negative, overflow, decimal, interrupt-disable, zero and carry. Every clock cycle the block may rewrite some of them, chosen by an operation-class strobe from the control logic.

The values written come from several sources:
- the ALU carry and overflow outputs;
- a zero and sign test on the result bus;
- a single instruction bit that supplies the value for explicit set and clear operations;
- a data bus byte, used for whole-register restores and for the bit-test operation;
- constant values for the clear-overflow operation and for interrupt entry.

The break flag has no storage. It appears only in the status byte that the block formats for a stack push.

The strobe vector is expected to carry at most one active bit per cycle. Each bit names an operation class, and that class decides which flags move and where their new values come from. A flag that the active class does not name keeps its value. Instruction decoding, the ALU, the stack engine and memory access are outside this block.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves interrupt-disable at 1 and negative, overflow, decimal, zero and carry at 0.
- R2: With `ctl` all zero, every flag keeps its value across the clock edge.
- R3: Strobe bit 0 (add/subtract) loads carry from `alu_carry`, overflow from `alu_ovf`, zero from (`res_bus` == 0) and negative from `res_bus` MSB; decimal and interrupt-disable are unchanged.
- R4: Strobe bit 1 (compare/shift/rotate) loads carry from `alu_carry`, and zero and negative from the result test; overflow, decimal and interrupt-disable are unchanged.
- R5: Strobe bit 2 (register write: load, transfer, logic, pull into a register) updates only zero and negative from the result test.
- R6: Strobe bit 3 (bit test) loads negative from `db` MSB, overflow from `db` bit MSB-1, and zero from (`res_bus` == 0); carry, decimal and interrupt-disable are unchanged.
- R7: Strobe bits 4, 5 and 6 write `ir_bit` into carry, interrupt-disable and decimal respectively, and leave every other flag unchanged.
- R8: Strobe bit 7 clears overflow to 0, whatever the other inputs are, and changes no other flag.
- R9: Strobe bit 8 (whole-register restore) copies `db` bits 7, 6, 3, 2, 1 and 0 into negative, overflow, decimal, interrupt-disable, zero and carry; `db` bits 5 and 4 have no effect.
- R10: Strobe bit 9 (break) and strobe bit 10 (accepted hardware interrupt) force interrupt-disable to 1 and leave the other flags unchanged.
- R11: `push_byte` presents the current stored flags combinationally as {N,V,1,B,D,I,Z,C} (bit 7 down to bit 0), where B is 1 exactly when strobe bit 9 is active in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 11 | Operation-class strobes, at most one bit set |
| ir_bit | input | 1 | Instruction bit giving the set/clear value |
| alu_carry | input | 1 | ALU carry output |
| alu_ovf | input | 1 | ALU signed overflow output |
| res_bus | input | DATA_W | Result bus tested for zero and sign |
| db | input | DATA_W | Data bus byte for restore and bit test |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_d | output | 1 | Decimal flag |
| flag_i | output | 1 | Interrupt-disable flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| push_byte | output | 8 | Status byte formatted for a stack push |

## Verification
The bench builds two copies with DATA_W=8: one uses the reduction-style zero detector and the other the pairwise OR-tree detector. Both are driven identically and checked against the same model. With an 8-bit result, the sweep covers every result and data value for every strobe class. That covers the single zero value, both sign values, and both settings of the ignored restore bits. Each strobe step is followed by an idle step, so flag holding is checked from many different flag states, and a reset in the middle of the run is checked as well.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

   // strobe bit positions on ctl
   localparam int OP_ARITH  = 0;
   localparam int OP_CMPSH  = 1;
   localparam int OP_WREG   = 2;
   localparam int OP_BIT    = 3;
   localparam int OP_SC_C   = 4;
   localparam int OP_SC_I   = 5;
   localparam int OP_SC_D   = 6;
   localparam int OP_CLR_V  = 7;
   localparam int OP_LOAD   = 8;
   localparam int OP_BRK    = 9;
   localparam int OP_IRQ    = 10;
   localparam int OP_COUNT  = 11;

   // stored flag indices
   localparam int FL_C      = 0;
   localparam int FL_Z      = 1;
   localparam int FL_I      = 2;
   localparam int FL_D      = 3;
   localparam int FL_V      = 4;
   localparam int FL_N      = 5;
   localparam int NUM_FLAGS = 6;

   // reset image: only interrupt-disable comes up set
   localparam logic [NUM_FLAGS-1:0] FLAG_RST = 6'b000100;

   // bit positions in the restore / pushed byte
   localparam int PB_C   = 0;
   localparam int PB_Z   = 1;
   localparam int PB_I   = 2;
   localparam int PB_D   = 3;
   localparam int PB_B   = 4;
   localparam int PB_ONE = 5;
   localparam int PB_V   = 6;
   localparam int PB_N   = 7;

endpackage

// File: rtl/sfu_zero_detect.sv
module sfu_zero_detect #(
   parameter int WIDTH = 8,
   parameter int STYLE = 0
) (
   input  logic [WIDTH-1:0] val,
   output logic             is_zero
);
   localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam int PAD_W  = 1 << LEVELS;

   generate
      if (STYLE == 0) begin : g_reduce
         assign is_zero = ~|val;
      end else begin : g_tree
         logic [LEVELS:0][PAD_W-1:0] lvl;
         assign lvl[0] = {{(PAD_W-WIDTH){1'b0}}, val};
         for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            localparam int NODES = PAD_W >> (l + 1);
            for (genvar k = 0; k < NODES; k++) begin : g_node
               assign lvl[l+1][k] = lvl[l][2*k] | lvl[l][2*k+1];
            end
            if (NODES < PAD_W) begin : g_fill
               assign lvl[l+1][PAD_W-1:NODES] = '0;
            end
         end
         assign is_zero = ~lvl[LEVELS][0];
      end
   endgenerate
endmodule

// File: rtl/sfu_flag_cell.sv
module sfu_flag_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= RST_VAL;
      else if (en) q <= d;
   end
endmodule

// File: rtl/sfu_next_logic.sv
module sfu_next_logic
   import sfu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_COUNT-1:0]  ctl,
   input  logic                 ir_bit,
   input  logic                 alu_carry,
   input  logic                 alu_ovf,
   input  logic                 res_zero,
   input  logic                 res_msb,
   input  logic [DATA_W-1:0]    db,
   output logic [NUM_FLAGS-1:0] wr_en,
   output logic [NUM_FLAGS-1:0] wr_val
);
   logic unused_db;
   assign unused_db = ^db;

   always_comb begin
      wr_en  = '0;
      wr_val = '0;
      if (ctl[OP_ARITH]) begin
         wr_en[FL_C] = 1'b1; wr_val[FL_C] = alu_carry;
         wr_en[FL_V] = 1'b1; wr_val[FL_V] = alu_ovf;
         wr_en[FL_Z] = 1'b1; wr_val[FL_Z] = res_zero;
         wr_en[FL_N] = 1'b1; wr_val[FL_N] = res_msb;
      end
      if (ctl[OP_CMPSH]) begin
         wr_en[FL_C] = 1'b1; wr_val[FL_C] = alu_carry;
         wr_en[FL_Z] = 1'b1; wr_val[FL_Z] = res_zero;
         wr_en[FL_N] = 1'b1; wr_val[FL_N] = res_msb;
      end
      if (ctl[OP_WREG]) begin
         wr_en[FL_Z] = 1'b1; wr_val[FL_Z] = res_zero;
         wr_en[FL_N] = 1'b1; wr_val[FL_N] = res_msb;
      end
      if (ctl[OP_BIT]) begin
         wr_en[FL_N] = 1'b1; wr_val[FL_N] = db[DATA_W-1];
         wr_en[FL_V] = 1'b1; wr_val[FL_V] = db[DATA_W-2];
         wr_en[FL_Z] = 1'b1; wr_val[FL_Z] = res_zero;
      end
      if (ctl[OP_SC_C]) begin
         wr_en[FL_C] = 1'b1; wr_val[FL_C] = ir_bit;
      end
      if (ctl[OP_SC_I]) begin
         wr_en[FL_I] = 1'b1; wr_val[FL_I] = ir_bit;
      end
      if (ctl[OP_SC_D]) begin
         wr_en[FL_D] = 1'b1; wr_val[FL_D] = ir_bit;
      end
      if (ctl[OP_CLR_V]) begin
         wr_en[FL_V] = 1'b1; wr_val[FL_V] = 1'b0;
      end
      if (ctl[OP_BRK] || ctl[OP_IRQ]) begin
         wr_en[FL_I] = 1'b1; wr_val[FL_I] = 1'b1;
      end
      if (ctl[OP_LOAD]) begin
         wr_en  = '1;
         wr_val[FL_N] = db[PB_N];
         wr_val[FL_V] = db[PB_V];
         wr_val[FL_D] = db[PB_D];
         wr_val[FL_I] = db[PB_I];
         wr_val[FL_Z] = db[PB_Z];
         wr_val[FL_C] = db[PB_C];
      end
   end
endmodule

// File: rtl/sfu_push_fmt.sv
module sfu_push_fmt
   import sfu_pkg::*;
(
   input  logic [NUM_FLAGS-1:0] flags,
   input  logic                 brk,
   output logic [7:0]           byte_o
);
   always_comb begin
      byte_o          = '0;
      byte_o[PB_N]    = flags[FL_N];
      byte_o[PB_V]    = flags[FL_V];
      byte_o[PB_ONE]  = 1'b1;
      byte_o[PB_B]    = brk;
      byte_o[PB_D]    = flags[FL_D];
      byte_o[PB_I]    = flags[FL_I];
      byte_o[PB_Z]    = flags[FL_Z];
      byte_o[PB_C]    = flags[FL_C];
   end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
   import sfu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ZERO_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [OP_COUNT-1:0] ctl,
   input  logic                ir_bit,
   input  logic                alu_carry,
   input  logic                alu_ovf,
   input  logic [DATA_W-1:0]   res_bus,
   input  logic [DATA_W-1:0]   db,
   output logic                flag_n,
   output logic                flag_v,
   output logic                flag_d,
   output logic                flag_i,
   output logic                flag_z,
   output logic                flag_c,
   output logic [7:0]          push_byte
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("status_flag_unit: DATA_W must be at least 8");
      end
      if (ZERO_STYLE < 0 || ZERO_STYLE > 1) begin : g_bad_style
         $error("status_flag_unit: ZERO_STYLE must be 0 or 1");
      end
   endgenerate

   logic                 res_zero;
   logic [NUM_FLAGS-1:0] wr_en;
   logic [NUM_FLAGS-1:0] wr_val;
   logic [NUM_FLAGS-1:0] flags_q;

   sfu_zero_detect #(.WIDTH(DATA_W), .STYLE(ZERO_STYLE)) u_zero (
      .val     (res_bus),
      .is_zero (res_zero)
   );

   sfu_next_logic #(.DATA_W(DATA_W)) u_next (
      .ctl       (ctl),
      .ir_bit    (ir_bit),
      .alu_carry (alu_carry),
      .alu_ovf   (alu_ovf),
      .res_zero  (res_zero),
      .res_msb   (res_bus[DATA_W-1]),
      .db        (db),
      .wr_en     (wr_en),
      .wr_val    (wr_val)
   );

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_cell
      sfu_flag_cell #(.RST_VAL(FLAG_RST[f])) u_cell (
         .clk (clk),
         .rst (rst),
         .en  (wr_en[f]),
         .d   (wr_val[f]),
         .q   (flags_q[f])
      );
   end

   sfu_push_fmt u_push (
      .flags  (flags_q),
      .brk    (ctl[OP_BRK]),
      .byte_o (push_byte)
   );

   assign flag_n = flags_q[FL_N];
   assign flag_v = flags_q[FL_V];
   assign flag_d = flags_q[FL_D];
   assign flag_i = flags_q[FL_I];
   assign flag_z = flags_q[FL_Z];
   assign flag_c = flags_q[FL_C];
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
   import sfu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ZERO_STYLE = 0
) (
   input logic                clk,
   input logic                rst,
   input logic [OP_COUNT-1:0] ctl,
   input logic                ir_bit,
   input logic                alu_carry,
   input logic                alu_ovf,
   input logic [DATA_W-1:0]   res_bus,
   input logic [DATA_W-1:0]   db,
   input logic                flag_n,
   input logic                flag_v,
   input logic                flag_d,
   input logic                flag_i,
   input logic                flag_z,
   input logic                flag_c,
   input logic [7:0]          push_byte
);
   logic [5:0] fl;
   assign fl = {flag_n, flag_v, flag_d, flag_i, flag_z, flag_c};

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (fl == 6'b000100)); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ctl == '0) |=> $stable(fl)); // R2

   AST_ARITH_CV: assert property (@(posedge clk) disable iff (rst)
      (ctl == (1 << OP_ARITH)) |=> (flag_c == $past(alu_carry)) && (flag_v == $past(alu_ovf))); // R3

   AST_CMPSH_KEEP_V: assert property (@(posedge clk) disable iff (rst)
      (ctl == (1 << OP_CMPSH)) |=> $stable(flag_v) && $stable(flag_d) && $stable(flag_i)); // R4

   AST_WREG_KEEP: assert property (@(posedge clk) disable iff (rst)
      (ctl == (1 << OP_WREG)) |=> $stable(flag_c) && $stable(flag_v) && $stable(flag_d) && $stable(flag_i)); // R5

   AST_BIT_NV: assert property (@(posedge clk) disable iff (rst)
      (ctl == (1 << OP_BIT)) |=> (flag_n == $past(db[DATA_W-1])) && (flag_v == $past(db[DATA_W-2]))); // R6

   AST_SETCLR_D: assert property (@(posedge clk) disable iff (rst)
      (ctl == (1 << OP_SC_D)) |=> (flag_d == $past(ir_bit)) && $stable(flag_c)); // R7

   AST_CLEAR_V: assert property (@(posedge clk) disable iff (rst)
      (ctl == (1 << OP_CLR_V)) |=> !flag_v); // R8

   AST_RESTORE: assert property (@(posedge clk) disable iff (rst)
      (ctl == (1 << OP_LOAD)) |=> (fl == $past({db[7], db[6], db[3], db[2], db[1], db[0]}))); // R9

   AST_INT_SETS_I: assert property (@(posedge clk) disable iff (rst)
      (ctl[OP_BRK] || ctl[OP_IRQ]) |=> flag_i); // R10

   AST_PUSH_FIXED: assert property (@(posedge clk) disable iff (rst)
      push_byte[5] && (push_byte[4] == ctl[OP_BRK]) && (push_byte[7] == flag_n)); // R11
endmodule

bind status_flag_unit sfu_checker #(.DATA_W(DATA_W), .ZERO_STYLE(ZERO_STYLE)) u_sfu_chk (.*);

// File: tb/test_status_flag_unit.sv
module test_status_flag_unit;
   localparam int W   = 8;
   localparam int OPS = 11;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [OPS-1:0] ctl = '0;
   logic           ir_bit = 1'b0;
   logic           alu_carry = 1'b0;
   logic           alu_ovf = 1'b0;
   logic [W-1:0]   res_bus = '0;
   logic [W-1:0]   db = '0;

   logic a_n, a_v, a_d, a_i, a_z, a_c;
   logic b_n, b_v, b_d, b_i, b_z, b_c;
   logic [7:0] a_pb, b_pb;

   int checks = 0;
   int failures = 0;

   // model state, order {N,V,D,I,Z,C}
   logic [5:0] m;

   always #5 clk = ~clk;

   status_flag_unit #(.DATA_W(W), .ZERO_STYLE(0)) i_status_flag_unit (
      .clk(clk), .rst(rst), .ctl(ctl), .ir_bit(ir_bit), .alu_carry(alu_carry),
      .alu_ovf(alu_ovf), .res_bus(res_bus), .db(db),
      .flag_n(a_n), .flag_v(a_v), .flag_d(a_d), .flag_i(a_i), .flag_z(a_z),
      .flag_c(a_c), .push_byte(a_pb));

   status_flag_unit #(.DATA_W(W), .ZERO_STYLE(1)) i_status_flag_unit_tree (
      .clk(clk), .rst(rst), .ctl(ctl), .ir_bit(ir_bit), .alu_carry(alu_carry),
      .alu_ovf(alu_ovf), .res_bus(res_bus), .db(db),
      .flag_n(b_n), .flag_v(b_v), .flag_d(b_d), .flag_i(b_i), .flag_z(b_z),
      .flag_c(b_c), .push_byte(b_pb));

   function automatic string tag_of(input int op);
      case (op)
         0: return "R3";  1: return "R4";  2: return "R5";  3: return "R6";
         4, 5, 6: return "R7";  7: return "R8";  8: return "R9";
         9, 10: return "R10";
         default: return "R2";
      endcase
   endfunction

   task automatic check_flags(input string tag);
      logic [5:0] act_a, act_b;
      act_a = {a_n, a_v, a_d, a_i, a_z, a_c};
      act_b = {b_n, b_v, b_d, b_i, b_z, b_c};
      checks++;
      if (act_a !== m) begin
         failures++;
         $display("FAIL %s reduce flags NVDIZC actual=%b expected=%b", tag, act_a, m);
      end
      checks++;
      if (act_b !== m) begin
         failures++;
         $display("FAIL %s tree flags NVDIZC actual=%b expected=%b", tag, act_b, m);
      end
   endtask

   task automatic check_push(input logic brk);
      logic [7:0] e;
      e = {m[5], m[4], 1'b1, brk, m[3], m[2], m[1], m[0]};
      checks++;
      if (a_pb !== e || b_pb !== e) begin
         failures++;
         $display("FAIL R11 push byte actual=%h/%h expected=%h", a_pb, b_pb, e);
      end
   endtask

   // one strobe step: drive at negedge, check push, check result at next negedge
   task automatic step(input int op, input logic [7:0] rv, input logic [7:0] dv,
                       input logic ib, input logic cy, input logic ov);
      logic z, n;
      ctl       = (op < OPS) ? (OPS'(1) << op) : '0;
      res_bus   = rv;
      db        = dv;
      ir_bit    = ib;
      alu_carry = cy;
      alu_ovf   = ov;
      #1;
      check_push(op == 9);
      z = (rv == 8'd0);
      n = rv[7];
      case (op)
         0: begin m[0] = cy; m[4] = ov; m[1] = z; m[5] = n; end
         1: begin m[0] = cy; m[1] = z; m[5] = n; end
         2: begin m[1] = z; m[5] = n; end
         3: begin m[5] = dv[7]; m[4] = dv[6]; m[1] = z; end
         4: m[0] = ib;
         5: m[2] = ib;
         6: m[3] = ib;
         7: m[4] = 1'b0;
         8: m = {dv[7], dv[6], dv[3], dv[2], dv[1], dv[0]};
         9, 10: m[2] = 1'b1;
         default: ;
      endcase
      @(negedge clk);
      check_flags(tag_of(op));
   endtask

   initial begin
      m = 6'b000100;
      @(negedge clk);
      @(negedge clk);
      check_flags("R1");
      rst = 1'b0;
      // exhaustive sweep: each class over all 256 values, each followed by an idle hold
      for (int op = 0; op < OPS; op++) begin
         for (int v = 0; v < 256; v++) begin
            step(op, 8'(v), 8'(v) ^ 8'h5A, v[0], v[1], v[2]);
            step(OPS, 8'(v) ^ 8'hFF, 8'(v), ~v[0], ~v[1], ~v[2]);
         end
      end
      // restore: bits 5 and 4 must not matter (R9)
      step(8, 8'h00, 8'b1111_0000, 1'b0, 1'b0, 1'b0);
      step(8, 8'h00, 8'b1100_1111, 1'b0, 1'b0, 1'b0);
      step(8, 8'h00, 8'b0011_0000, 1'b0, 1'b0, 1'b0);
      // clear-V with everything else high (R8)
      step(8, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);
      step(7, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1);
      // interrupt entry with I already clear (R10)
      step(5, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      step(10, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      step(5, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      step(9, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      // reset in mid-run with a strobe present (R1)
      step(8, 8'h00, 8'hCB, 1'b0, 1'b0, 1'b0);
      rst = 1'b1;
      ctl = OPS'(1) << 8;
      db  = 8'hFF;
      @(negedge clk);
      m = 6'b000100;
      check_flags("R1");
      rst = 1'b0;
      ctl = '0;
      @(negedge clk);
      check_flags("R2");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1000000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule